// File: doc/BRIEF.md
# Retire-Time Virtual-Branch Trainer

When an indirect branch retires, this sequencer replays the chain of virtual conditional branches that the front end used to predict it. It then emits the updates that keep the shared conditional direction predictor and the branch target buffer (BTB) in step with what actually happened. Each virtual branch has its own virtual PC and virtual history. Both are derived from the real PC and global history exactly as the prediction side derives them, so each update lands on the same predictor entry that was consulted.

A retire request carries the branch PC, the global history, the resolved target, a flag saying whether the prediction was right, and the iteration at which the right target was found.

- **Correct prediction.** The walk is purely arithmetic. It needs no BTB access.
- **Misprediction.** The walk reads the BTB once per virtual slot, and only when the BTB grants it a port. It stops at the first slot that already holds the resolved target.
- **No slot holds the target.** The target is written into a chosen slot. An empty slot is chosen first. Otherwise the slot with the smallest use counter is chosen.

The block accepts one request at a time and raises `busy` while it works. Both predictor storages live outside the block.

Top module: `vbt_trainer`

## Requirements
- R1: After reset, and whenever `busy` is low, no update, read, replacement or insert command is asserted.
- R2: Iterations are numbered from 0.
  - Iteration i uses virtual PC = PC XOR H(i). H(0) = 0, and H(i) is the low PC_W bits of i × 0x9E3779B1.
  - Iteration i uses virtual history = GHR shifted left by i, truncated to GHR_W bits.
- R3: For a correct prediction found at iteration k, one direction update is issued per cycle starting the cycle after acceptance.
  - Iterations 0..k-1 are trained not-taken, then iteration k is trained taken.
  - No BTB read and no insert is issued.
- R4: For a correct prediction, a replacement update for the iteration-k virtual PC is issued in the same cycle as its taken update.
- R5: After a misprediction, each iteration requests a BTB read at its virtual PC, and the response is taken in the cycle after the grant. A slot that is empty (`btb_rsp_full`=0), or that holds a different target, is trained not-taken in that response cycle.
- R6: On a misprediction, the first iteration whose response holds the resolved target has three effects in the same cycle, and the walk then ends:
  - it is trained taken;
  - it gets a replacement update;
  - no further read is issued.
- R7: If none of the MAX_ITER iterations matches, the insertion cycle follows the last response. In that cycle the block issues an insert of the resolved target at the victim's virtual PC, together with a taken update at the victim's virtual PC and history.
- R8: Victim choice is made in this order:
  1. the earliest empty slot;
  2. otherwise the slot with the smallest `btb_rsp_cnt`, with ties going to the earliest iteration.
- R9: While a read request is not granted, the request stays asserted with an unchanged virtual PC and the walk does not advance.
- R10: `busy` rises the cycle after a request is accepted and falls after the walk's final command. A `ret_valid` while `busy` is high is ignored.
- R11: A replacement update and an insert are never issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ret_valid | input | 1 | Retire request, accepted when `busy` is low |
| ret_pc | input | PC_W | Indirect branch PC |
| ret_ghr | input | GHR_W | Global history at prediction |
| ret_target | input | PC_W | Resolved target |
| ret_correct | input | 1 | Prediction was correct |
| ret_iter | input | ITER_W | Iteration of the correct prediction |
| busy | output | 1 | Walk in progress |
| dp_upd_valid | output | 1 | Direction update command |
| dp_upd_vpc | output | PC_W | Virtual PC of the update |
| dp_upd_vghr | output | GHR_W | Virtual history of the update |
| dp_upd_taken | output | 1 | Train taken (1) or not-taken (0) |
| btb_rd_req | output | 1 | BTB read request |
| btb_rd_vpc | output | PC_W | Read address |
| btb_rd_gnt | input | 1 | A BTB port is free this cycle |
| btb_rsp_full | input | 1 | Read slot holds a target |
| btb_rsp_target | input | PC_W | Target in the read slot |
| btb_rsp_cnt | input | CNT_W | Use counter of the read slot |
| btb_repl_valid | output | 1 | Replacement-state update command |
| btb_repl_vpc | output | PC_W | Slot whose counter is bumped |
| btb_ins_valid | output | 1 | Insert command |
| btb_ins_vpc | output | PC_W | Slot receiving the target |
| btb_ins_target | output | PC_W | Target written |

## Verification
The bench builds the block with PC_W=16, GHR_W=8, MAX_ITER=4 and CNT_W=2. With four iterations, a walk that runs to the end without a match is only nine cycles long. That makes it cheap to cover victim choice between empty slots, the lowest counter, and tied counters. It also makes it cheap to check that a correct prediction at the last iteration walks every not-taken step. The narrow counter lets tie and minimum patterns be set up from a handful of values, and the 16-bit PC keeps the expected hash values easy to audit.

// File: rtl/vbt_pkg.sv
// Package for the virtual-branch trainer.
// Holds the walk state encoding and the per-iteration hash constant generator.
// Assumes the prediction side uses the same hash so that trained entries line up.
package vbt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRAIN,
        ST_RDREQ,
        ST_RDRSP,
        ST_INSERT
    } walk_state_t;

    // Hash constant for one iteration; iteration 0 yields zero.
    function automatic logic [31:0] slot_hash(input logic [31:0] idx);
        return idx * 32'h9E37_79B1;
    endfunction

endpackage

// File: rtl/vbt_vaddr_gen.sv
// Virtual address generator.
// Produces the virtual PC and virtual history of one iteration.
// Purely combinational; the hash is truncated or zero-extended to PC_W.
module vbt_vaddr_gen #(
    parameter int PC_W   = 32,
    parameter int GHR_W  = 16,
    parameter int ITER_W = 4
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [GHR_W-1:0]  ghr,
    input  logic [ITER_W-1:0] iter,
    output logic [PC_W-1:0]   vpc,
    output logic [GHR_W-1:0]  vghr
);
    import vbt_pkg::*;

    logic [31:0]     hash_raw;
    logic [PC_W-1:0] hash_w;

    // Form the hash for this iteration and fold it into the PC; shift the history.
    always_comb begin
        hash_raw = slot_hash(32'(iter));
        hash_w   = PC_W'(hash_raw);
        vpc      = pc ^ hash_w;
        vghr     = ghr << iter;
    end

endmodule

// File: rtl/vbt_victim_sel.sv
// Victim selector.
// Tracks, across one misprediction walk, the best slot for inserting a new target.
// Ranking: an empty slot beats a filled one, and the first empty wins.
// Among filled slots the lower use counter wins; ties keep the earlier iteration.
// Assumes candidates arrive in increasing iteration order after a clear.
module vbt_victim_sel #(
    parameter int ITER_W = 4,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              take,
    input  logic [ITER_W-1:0] cand_iter,
    input  logic              cand_empty,
    input  logic [CNT_W-1:0]  cand_cnt,
    output logic [ITER_W-1:0] best_iter
);
    logic              have_q;
    logic              best_empty_q;
    logic [CNT_W-1:0]  best_cnt_q;
    logic [ITER_W-1:0] best_iter_q;
    logic              better;

    // Decide whether the candidate outranks the slot held so far.
    always_comb begin
        better = !have_q
              || (cand_empty && !best_empty_q)
              || (!cand_empty && !best_empty_q && (cand_cnt < best_cnt_q));
    end

    // Hold the best candidate; forget it at the start of a walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_q       <= 1'b0;
            best_empty_q <= 1'b0;
            best_cnt_q   <= '0;
            best_iter_q  <= '0;
        end else if (clear) begin
            have_q       <= 1'b0;
            best_empty_q <= 1'b0;
        end else if (take && better) begin
            have_q       <= 1'b1;
            best_empty_q <= cand_empty;
            best_cnt_q   <= cand_cnt;
            best_iter_q  <= cand_iter;
        end
    end

    assign best_iter = best_iter_q;

endmodule

// File: rtl/vbt_walk_fsm.sv
// Walk sequencer.
// Steps through virtual slots after a retire.
// A correct prediction is walked arithmetically, one slot per cycle.
// A misprediction is walked with a read request and a response cycle per slot.
// Assumes a BTB response arrives in the cycle after the grant.
// A requested iteration above the last one is clamped to the last.
module vbt_walk_fsm #(
    parameter int MAX_ITER = 12,
    parameter int ITER_W   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 start_correct,
    input  logic [ITER_W-1:0]    start_iter,
    input  logic                 rd_gnt,
    input  logic                 rsp_match,
    output vbt_pkg::walk_state_t state,
    output logic [ITER_W-1:0]    iter,
    output logic                 at_k,
    output logic                 at_last
);
    import vbt_pkg::*;

    localparam logic [ITER_W-1:0] LAST    = ITER_W'(MAX_ITER - 1);
    localparam logic [ITER_W:0]   LAST_WX = (ITER_W+1)'(MAX_ITER - 1);

    walk_state_t       state_q;
    logic [ITER_W-1:0] iter_q;
    logic [ITER_W-1:0] k_q;
    logic [ITER_W-1:0] k_clamped;

    // Clamp the reported hit iteration to the walk bound.
    always_comb begin
        k_clamped = ({1'b0, start_iter} > LAST_WX) ? LAST : start_iter;
    end

    // Advance the walk state and the iteration index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            iter_q  <= '0;
            k_q     <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= start_correct ? ST_CTRAIN : ST_RDREQ;
                        iter_q  <= '0;
                        k_q     <= k_clamped;
                    end
                end
                ST_CTRAIN: begin
                    if (iter_q == k_q) state_q <= ST_IDLE;
                    else               iter_q  <= iter_q + ITER_W'(1);
                end
                ST_RDREQ: begin
                    if (rd_gnt) state_q <= ST_RDRSP;
                end
                ST_RDRSP: begin
                    if (rsp_match) begin
                        state_q <= ST_IDLE;
                    end else if (iter_q == LAST) begin
                        state_q <= ST_INSERT;
                    end else begin
                        iter_q  <= iter_q + ITER_W'(1);
                        state_q <= ST_RDREQ;
                    end
                end
                ST_INSERT: state_q <= ST_IDLE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    assign state   = state_q;
    assign iter    = iter_q;
    assign at_k    = (iter_q == k_q);
    assign at_last = (iter_q == LAST);

endmodule

// File: rtl/vbt_trainer.sv
// Retire-time virtual-branch trainer (top).
// Latches one retired indirect branch and walks its virtual slots.
// Emits direction-predictor training, BTB reads, replacement bumps and inserts.
// Assumes predictor and BTB storage are external.
// Assumes a granted read answers one cycle later.
module vbt_trainer #(
    parameter int PC_W     = 32,
    parameter int GHR_W    = 16,
    parameter int MAX_ITER = 12,
    parameter int CNT_W    = 3,
    parameter int ITER_W   = (MAX_ITER > 1) ? $clog2(MAX_ITER) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ret_valid,
    input  logic [PC_W-1:0]   ret_pc,
    input  logic [GHR_W-1:0]  ret_ghr,
    input  logic [PC_W-1:0]   ret_target,
    input  logic              ret_correct,
    input  logic [ITER_W-1:0] ret_iter,
    output logic              busy,
    output logic              dp_upd_valid,
    output logic [PC_W-1:0]   dp_upd_vpc,
    output logic [GHR_W-1:0]  dp_upd_vghr,
    output logic              dp_upd_taken,
    output logic              btb_rd_req,
    output logic [PC_W-1:0]   btb_rd_vpc,
    input  logic              btb_rd_gnt,
    input  logic              btb_rsp_full,
    input  logic [PC_W-1:0]   btb_rsp_target,
    input  logic [CNT_W-1:0]  btb_rsp_cnt,
    output logic              btb_repl_valid,
    output logic [PC_W-1:0]   btb_repl_vpc,
    output logic              btb_ins_valid,
    output logic [PC_W-1:0]   btb_ins_vpc,
    output logic [PC_W-1:0]   btb_ins_target
);
    import vbt_pkg::*;

    walk_state_t       state;
    logic [ITER_W-1:0] iter;
    logic              at_k;
    logic              at_last;
    logic [ITER_W-1:0] vict_iter;
    logic [ITER_W-1:0] iter_sel;
    logic [PC_W-1:0]   vpc;
    logic [GHR_W-1:0]  vghr;
    logic              accept;
    logic              rsp_match;
    logic              in_ctrain, in_rdreq, in_rdrsp, in_insert;

    logic [PC_W-1:0]   pc_q;
    logic [GHR_W-1:0]  ghr_q;
    logic [PC_W-1:0]   tgt_q;

    assign accept = ret_valid && (state == ST_IDLE);

    // Capture the retired branch when a walk starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= '0;
            ghr_q <= '0;
            tgt_q <= '0;
        end else if (accept) begin
            pc_q  <= ret_pc;
            ghr_q <= ret_ghr;
            tgt_q <= ret_target;
        end
    end

    vbt_walk_fsm #(
        .MAX_ITER (MAX_ITER),
        .ITER_W   (ITER_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (accept),
        .start_correct (ret_correct),
        .start_iter    (ret_iter),
        .rd_gnt        (btb_rd_gnt),
        .rsp_match     (rsp_match),
        .state         (state),
        .iter          (iter),
        .at_k          (at_k),
        .at_last       (at_last)
    );

    // Decode the walk state into one-hot phase flags.
    always_comb begin
        in_ctrain = (state == ST_CTRAIN);
        in_rdreq  = (state == ST_RDREQ);
        in_rdrsp  = (state == ST_RDRSP);
        in_insert = (state == ST_INSERT);
    end

    // Compare the BTB response against the resolved target.
    always_comb begin
        rsp_match = btb_rsp_full && (btb_rsp_target == tgt_q);
    end

    vbt_victim_sel #(
        .ITER_W (ITER_W),
        .CNT_W  (CNT_W)
    ) u_victim (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (accept),
        .take       (in_rdrsp && !rsp_match),
        .cand_iter  (iter),
        .cand_empty (!btb_rsp_full),
        .cand_cnt   (btb_rsp_cnt),
        .best_iter  (vict_iter)
    );

    // Address the victim during insertion, else the current iteration.
    always_comb begin
        iter_sel = in_insert ? vict_iter : iter;
    end

    vbt_vaddr_gen #(
        .PC_W   (PC_W),
        .GHR_W  (GHR_W),
        .ITER_W (ITER_W)
    ) u_vaddr (
        .pc   (pc_q),
        .ghr  (ghr_q),
        .iter (iter_sel),
        .vpc  (vpc),
        .vghr (vghr)
    );

    // Build the command outputs from the phase and the response.
    always_comb begin
        busy           = (state != ST_IDLE);
        dp_upd_valid   = in_ctrain || in_rdrsp || in_insert;
        dp_upd_taken   = (in_ctrain && at_k) || (in_rdrsp && rsp_match) || in_insert;
        dp_upd_vpc     = vpc;
        dp_upd_vghr    = vghr;
        btb_rd_req     = in_rdreq;
        btb_rd_vpc     = vpc;
        btb_repl_valid = (in_ctrain && at_k) || (in_rdrsp && rsp_match);
        btb_repl_vpc   = vpc;
        btb_ins_valid  = in_insert;
        btb_ins_vpc    = vpc;
        btb_ins_target = tgt_q;
    end

endmodule

// File: rtl/vbt_trainer_chk.sv
// Property checker for the virtual-branch trainer; attached with bind below.
// Observes ports only.
module vbt_trainer_chk #(
    parameter int PC_W   = 32,
    parameter int ITER_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ret_valid,
    input logic            busy,
    input logic            dp_upd_valid,
    input logic [PC_W-1:0] dp_upd_vpc,
    input logic            dp_upd_taken,
    input logic            btb_rd_req,
    input logic [PC_W-1:0] btb_rd_vpc,
    input logic            btb_rd_gnt,
    input logic            btb_repl_valid,
    input logic [PC_W-1:0] btb_repl_vpc,
    input logic            btb_ins_valid,
    input logic [PC_W-1:0] btb_ins_vpc
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(dp_upd_valid || btb_rd_req || btb_repl_valid || btb_ins_valid));

    p_repl_with_taken_r4: assert property (@(posedge clk) disable iff (!rst_n)
        btb_repl_valid |-> (dp_upd_valid && dp_upd_taken && dp_upd_vpc == btb_repl_vpc));

    p_taken_ends_walk_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_upd_valid && dp_upd_taken) |=> !busy);

    p_insert_with_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
        btb_ins_valid |-> (dp_upd_valid && dp_upd_taken && dp_upd_vpc == btb_ins_vpc));

    p_read_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (btb_rd_req && !btb_rd_gnt) |=> (btb_rd_req && $stable(btb_rd_vpc)));

    p_accept_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && !busy) |=> busy);

    p_no_repl_and_ins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(btb_repl_valid && btb_ins_valid));

endmodule

bind vbt_trainer vbt_trainer_chk #(
    .PC_W   (PC_W),
    .ITER_W (ITER_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ret_valid      (ret_valid),
    .busy           (busy),
    .dp_upd_valid   (dp_upd_valid),
    .dp_upd_vpc     (dp_upd_vpc),
    .dp_upd_taken   (dp_upd_taken),
    .btb_rd_req     (btb_rd_req),
    .btb_rd_vpc     (btb_rd_vpc),
    .btb_rd_gnt     (btb_rd_gnt),
    .btb_repl_valid (btb_repl_valid),
    .btb_repl_vpc   (btb_repl_vpc),
    .btb_ins_valid  (btb_ins_valid),
    .btb_ins_vpc    (btb_ins_vpc)
);

// File: tb/tb_vbt_trainer.sv
`timescale 1ns/1ps
module tb_vbt_trainer;
    localparam int PC_W = 16, GHR_W = 8, MAX_ITER = 4, CNT_W = 2, ITER_W = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ret_valid = 1'b0, ret_correct = 1'b0;
    logic [PC_W-1:0] ret_pc = '0, ret_target = '0;
    logic [GHR_W-1:0] ret_ghr = '0;
    logic [ITER_W-1:0] ret_iter = '0;
    logic busy, dp_upd_valid, dp_upd_taken, btb_rd_req, btb_repl_valid, btb_ins_valid;
    logic [PC_W-1:0] dp_upd_vpc, btb_rd_vpc, btb_repl_vpc, btb_ins_vpc, btb_ins_target;
    logic [GHR_W-1:0] dp_upd_vghr;
    logic btb_rd_gnt = 1'b0, btb_rsp_full = 1'b0;
    logic [PC_W-1:0] btb_rsp_target = '0;
    logic [CNT_W-1:0] btb_rsp_cnt = '0;

    always #10 clk = ~clk;   // 50 MHz

    vbt_trainer #(.PC_W(PC_W), .GHR_W(GHR_W), .MAX_ITER(MAX_ITER), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_pc(ret_pc), .ret_ghr(ret_ghr),
        .ret_target(ret_target), .ret_correct(ret_correct), .ret_iter(ret_iter), .busy(busy),
        .dp_upd_valid(dp_upd_valid), .dp_upd_vpc(dp_upd_vpc), .dp_upd_vghr(dp_upd_vghr),
        .dp_upd_taken(dp_upd_taken), .btb_rd_req(btb_rd_req), .btb_rd_vpc(btb_rd_vpc),
        .btb_rd_gnt(btb_rd_gnt), .btb_rsp_full(btb_rsp_full), .btb_rsp_target(btb_rsp_target),
        .btb_rsp_cnt(btb_rsp_cnt), .btb_repl_valid(btb_repl_valid), .btb_repl_vpc(btb_repl_vpc),
        .btb_ins_valid(btb_ins_valid), .btb_ins_vpc(btb_ins_vpc), .btb_ins_target(btb_ins_target));

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // Bench BTB contents per iteration for the current scenario
    logic tb_full [4];
    logic [PC_W-1:0] tb_tgt [4];
    logic [CNT_W-1:0] tb_cnt [4];

    // Recorded events
    logic [PC_W-1:0] ev_dp_vpc [32];
    logic [GHR_W-1:0] ev_dp_vghr [32];
    logic ev_dp_tk [32];
    logic [PC_W-1:0] ev_rd [32];
    logic [PC_W-1:0] ev_repl [32];
    logic [PC_W-1:0] ev_ins [32];
    logic [PC_W-1:0] ev_ins_tgt [32];
    int n_dp, n_rd, n_repl, n_ins, n_stall;
    bit hold_bad, first_busy;
    logic [PC_W-1:0] cur_pc, cur_tgt;
    logic [GHR_W-1:0] cur_ghr;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [PC_W-1:0] exp_vpc(input logic [PC_W-1:0] pc, input int i);
        logic [31:0] h;
        h = 32'(i) * 32'h9E37_79B1;
        return pc ^ h[PC_W-1:0];
    endfunction

    function automatic logic [GHR_W-1:0] exp_vghr(input logic [GHR_W-1:0] g, input int i);
        return g << i;
    endfunction

    // Check one recorded direction update against iteration it.
    task automatic chk_dp(input int idx, input int it, input bit tk, input string req);
        chk(ev_dp_vpc[idx] == exp_vpc(cur_pc, it), {req, " R2 dp vpc"}, 32'(ev_dp_vpc[idx]), 32'(exp_vpc(cur_pc, it)));
        chk(ev_dp_vghr[idx] == exp_vghr(cur_ghr, it), {req, " R2 dp vghr"}, 32'(ev_dp_vghr[idx]), 32'(exp_vghr(cur_ghr, it)));
        chk(ev_dp_tk[idx] == tk, {req, " dp taken"}, 32'(ev_dp_tk[idx]), 32'(tk));
    endtask

    // Launch one retire and record all commands until the walk ends.
    task automatic walk(input logic [PC_W-1:0] pc, input logic [GHR_W-1:0] ghr, input logic [PC_W-1:0] tgt,
                        input bit corr, input int k, input int deny, input bit inject);
        bit granted = 0;
        int dcnt = 0;
        logic [PC_W-1:0] last_vpc = '0;
        cur_pc = pc; cur_ghr = ghr; cur_tgt = tgt;
        n_dp = 0; n_rd = 0; n_repl = 0; n_ins = 0; n_stall = 0; hold_bad = 0; first_busy = 0;
        @(negedge clk);
        ret_valid = 1; ret_pc = pc; ret_ghr = ghr; ret_target = tgt; ret_correct = corr; ret_iter = ITER_W'(k);
        @(negedge clk);
        ret_valid = 0;
        for (int cyc = 0; cyc < 200; cyc++) begin
            if (granted) begin
                btb_rsp_full = tb_full[n_rd-1]; btb_rsp_target = tb_tgt[n_rd-1]; btb_rsp_cnt = tb_cnt[n_rd-1];
                granted = 0;
            end
            if (inject && cyc == 2) begin
                ret_valid = 1; ret_pc = pc ^ 16'h5555; ret_correct = 1; ret_iter = '0;
            end else begin
                ret_valid = 0;
            end
            #1;
            if (cyc == 0) first_busy = busy;
            if (!busy) break;
            if (dp_upd_valid && n_dp < 32) begin
                ev_dp_vpc[n_dp] = dp_upd_vpc; ev_dp_vghr[n_dp] = dp_upd_vghr; ev_dp_tk[n_dp] = dp_upd_taken; n_dp++;
            end
            if (btb_repl_valid && n_repl < 32) begin ev_repl[n_repl] = btb_repl_vpc; n_repl++; end
            if (btb_ins_valid && n_ins < 32) begin
                ev_ins[n_ins] = btb_ins_vpc; ev_ins_tgt[n_ins] = btb_ins_target; n_ins++;
            end
            if (btb_rd_req) begin
                if (dcnt > 0 && btb_rd_vpc != last_vpc) hold_bad = 1;
                last_vpc = btb_rd_vpc;
                if (dcnt < deny) begin
                    dcnt++; n_stall++; btb_rd_gnt = 0;
                end else if (n_rd < 4) begin
                    ev_rd[n_rd] = btb_rd_vpc; n_rd++; btb_rd_gnt = 1; granted = 1; dcnt = 0;
                end else begin
                    n_rd++; btb_rd_gnt = 0;
                end
            end else begin
                btb_rd_gnt = 0;
            end
            @(negedge clk);
        end
        ret_valid = 0; btb_rd_gnt = 0;
    endtask

    task automatic t_reset;
        @(negedge clk); #1;
        chk(busy == 0, "R1 busy after reset", 32'(busy), 0);
        chk(!(dp_upd_valid || btb_rd_req || btb_repl_valid || btb_ins_valid), "R1 commands after reset",
            32'({dp_upd_valid, btb_rd_req, btb_repl_valid, btb_ins_valid}), 0);
    endtask

    task automatic t_correct(input int k);
        walk(16'h1234 + 16'(k), 8'hA5, 16'h4000, 1, k, 0, 0);
        chk(first_busy == 1, "R10 busy after accept", 32'(first_busy), 1);
        chk(n_dp == k + 1, "R3 update count", 32'(n_dp), 32'(k + 1));
        for (int i = 0; i <= k && i < n_dp; i++) chk_dp(i, i, i == k, "R3");
        chk(n_rd == 0, "R3 no reads", 32'(n_rd), 0);
        chk(n_ins == 0, "R3 no insert", 32'(n_ins), 0);
        chk(n_repl == 1, "R4 repl count", 32'(n_repl), 1);
        chk(ev_repl[0] == exp_vpc(cur_pc, k), "R4 repl vpc", 32'(ev_repl[0]), 32'(exp_vpc(cur_pc, k)));
    endtask

    task automatic t_mis_hit(input int deny);
        tb_full = '{1, 1, 1, 1};
        tb_tgt  = '{16'h0111, 16'h0222, 16'h7ABC, 16'h7ABC};
        tb_cnt  = '{0, 0, 0, 0};
        walk(16'hBEEF, 8'h3C, 16'h7ABC, 0, 0, deny, 0);
        chk(n_rd == 3, "R6 read count stops at match", 32'(n_rd), 3);
        for (int i = 0; i < 3 && i < n_rd; i++)
            chk(ev_rd[i] == exp_vpc(cur_pc, i), "R5 read vpc", 32'(ev_rd[i]), 32'(exp_vpc(cur_pc, i)));
        chk(n_dp == 3, "R5 update count", 32'(n_dp), 3);
        if (n_dp >= 3) begin chk_dp(0, 0, 0, "R5"); chk_dp(1, 1, 0, "R5"); chk_dp(2, 2, 1, "R6"); end
        chk(n_repl == 1 && ev_repl[0] == exp_vpc(cur_pc, 2), "R6 repl at match", 32'(ev_repl[0]), 32'(exp_vpc(cur_pc, 2)));
        chk(n_ins == 0, "R6 no insert", 32'(n_ins), 0);
        if (deny > 0) begin
            chk(n_stall == 3 * deny, "R9 stall cycles", 32'(n_stall), 32'(3 * deny));
            chk(hold_bad == 0, "R9 read vpc held", 32'(hold_bad), 0);
        end
    endtask

    task automatic t_mis_insert(input string tag, input int vict, input bit inject);
        walk(16'h0F0F, 8'h81, 16'h5A5A, 0, 0, 0, inject);
        chk(n_rd == 4, {tag, " R7 full walk reads"}, 32'(n_rd), 4);
        chk(n_dp == 5, {tag, " R7 update count"}, 32'(n_dp), 5);
        for (int i = 0; i < 4 && i < n_dp; i++) chk_dp(i, i, 0, {tag, " R5"});
        if (n_dp == 5) chk_dp(4, vict, 1, {tag, " R7 R8 victim"});
        chk(n_ins == 1, {tag, " R7 insert count"}, 32'(n_ins), 1);
        chk(ev_ins[0] == exp_vpc(cur_pc, vict), {tag, " R8 insert vpc"}, 32'(ev_ins[0]), 32'(exp_vpc(cur_pc, vict)));
        chk(ev_ins_tgt[0] == cur_tgt, {tag, " R7 insert target"}, 32'(ev_ins_tgt[0]), 32'(cur_tgt));
        chk(n_repl == 0, {tag, " R11 no repl on insert"}, 32'(n_repl), 0);
    endtask

    task automatic t_lfu;
        tb_full = '{1, 1, 1, 1};
        tb_tgt  = '{16'h1111, 16'h2222, 16'h3333, 16'h4444};
        tb_cnt  = '{3, 1, 2, 1};
        t_mis_insert("lfu tie", 1, 0);
    endtask

    task automatic t_empty;
        tb_full = '{1, 1, 0, 0};
        tb_tgt  = '{16'h1111, 16'h2222, 16'h5A5A, 16'h0000};
        tb_cnt  = '{0, 2, 3, 3};
        t_mis_insert("empty first", 2, 0);
    endtask

    task automatic t_busy_ignore;
        tb_full = '{1, 1, 1, 1};
        tb_tgt  = '{16'h1111, 16'h2222, 16'h3333, 16'h4444};
        tb_cnt  = '{2, 2, 2, 2};
        t_mis_insert("R10 ignore", 0, 1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1;
            chk(busy == 0 && dp_upd_valid == 0, "R10 no walk from ignored request",
                32'({busy, dp_upd_valid}), 0);
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_correct(0);
        t_correct(3);
        t_mis_hit(0);
        t_lfu();
        t_empty();
        t_mis_hit(2);
        t_busy_ignore();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule